// File: doc/BRIEF.md
# Skewed Hybrid Branch Direction Predictor

This block predicts whether a conditional branch is taken. It holds four tables of two-bit saturating counters. A bimodal table is indexed by the branch address alone. Two skewed global tables are indexed by two different hashes of the address and the global history. The fourth table is a chooser. The chooser decides whether the final answer comes from the bimodal table alone or from the majority vote of the three direction tables. Each table keeps its direction bits and its hysteresis bits in two separate single-bit memories.

A fetch stage presents a branch address and the current global history. One cycle later it receives the prediction, together with the four table indices and the counter bits that were read. When the branch resolves, the fetch stage returns those indices and bits with the real outcome on the update port. The block then applies a selective training policy in a single write cycle. Banks that already agree are left alone. Only the banks that helped are reinforced. The chooser trains only when the bimodal answer and the vote differ.

After reset the block clears every table entry on its own, then raises its ready flag.

Top module: `gskew_predictor`

## Requirements
- R1: After reset, `rdy` stays low for exactly 2^IDX_W clock edges. During that time every entry of every table is cleared to direction 0, hysteresis 0, which makes the chooser select the bimodal bank. Predict requests made while `rdy` is low produce no response. Once `rdy` is high it stays high.
- R2: A predict request accepted while `rdy` is high raises `rsp_valid` on the next clock edge. At that edge the response indices and bits are loaded; they hold until the next request.
- R3: Indices are formed from two values. `a` is the XOR of the IDX_W-bit chunks of `pred_pc`, zero padded at the top. `f` is the same fold applied to `pred_hist`. The index lanes are: lane 0 (bimodal) = `a`; lane 1 (G0) = `a` XOR `f` rotated left by one; lane 2 (G1) = bit-reversed `a` XOR `f` rotated right by one; lane 3 (chooser) = `a` XOR `f`. The same lane order applies to `rsp_idx`, `rsp_pbit`, `rsp_hbit`, `upd_idx`, `upd_pbit` and `upd_hbit`.
- R4: `rsp_taken` is the majority of the lane 0, 1 and 2 direction bits when the chooser direction bit is 1. Otherwise it is the lane 0 direction bit.
- R5: A counter stepped toward an outcome changes as follows. If its direction bit equals the outcome, its hysteresis bit becomes 1. If its direction bit differs and its hysteresis bit is 1, the hysteresis bit becomes 0. If its direction bit differs and its hysteresis bit is 0, the direction bit takes the outcome and the hysteresis bit stays 0.
- R6: If the prediction was correct and the three direction banks agreed, the update writes nothing.
- R7: If the prediction was correct but the direction banks disagreed, each direction bank whose bit equals the outcome gets hysteresis 1, and the other direction banks are untouched. When the bimodal bit and the vote differ, the chooser is stepped toward 1 if the vote was right and toward 0 if the bimodal bank was right.
- R8: On a misprediction, the chooser is first stepped as in R7 whenever the bimodal bit and the vote differ. The selection is then recomputed with the chooser's new direction bit. If the recomputed answer matches the outcome, only the direction banks that were right get hysteresis 1. Otherwise all three direction banks are stepped toward the outcome.
- R9: An update takes effect at the clock edge where `upd_valid` is high. A prediction read at that same edge from the same entry returns the contents from before the write. A later prediction sees the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rdy | output | 1 | High once the table clear has finished |
| pred_valid | input | 1 | Predict request |
| pred_pc | input | PC_W | Branch address without byte-offset bits |
| pred_hist | input | HIST_W | Global outcome history |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_taken | output | 1 | Final direction prediction |
| rsp_idx | output | 4 x IDX_W | Entry index per lane |
| rsp_pbit | output | 4 | Direction bit read per lane |
| rsp_hbit | output | 4 | Hysteresis bit read per lane |
| upd_valid | input | 1 | Update request |
| upd_taken | input | 1 | Resolved branch outcome |
| upd_idx | input | 4 x IDX_W | Indices returned from the response |
| upd_pbit | input | 4 | Direction bits returned from the response |
| upd_hbit | input | 4 | Hysteresis bits returned from the response |

## Verification
The bench walks one branch through each training case:
- An agreeing correct prediction must leave the hysteresis bits at 0. A design that strengthens anyway would show them set.
- A correct-but-split case must reinforce only the winning banks. A design that misses the chooser, or trains the wrong direction, would show the wrong selection on the next read.
- Both halves of the misprediction rule are covered. The bench checks that the recomputed selection suppresses the blanket step. A design that steps every bank unconditionally would disturb a bank that was already right.

The bench also checks three more things:
- Reads that collide with a write must return the old contents.
- The clear must last exactly one pass over the table.
- The G1 bit reversal and the two rotation directions must hold across varied addresses. An index hash that is swapped or mis-rotated shows up as a lane mismatch.

// File: rtl/gskew_pkg.sv
package gskew_pkg;

  localparam int NLANE  = 4;
  localparam int L_BIM  = 0;
  localparam int L_G0   = 1;
  localparam int L_G1   = 2;
  localparam int L_META = 3;

  typedef struct packed {
    logic dir;
    logic hyst;
  } ctr_t;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // Move a split two-bit counter one step toward the outcome.
  function automatic ctr_t ctr_step(input ctr_t c, input logic outcome);
    ctr_t n;
    n = c;
    if (c.dir == outcome) begin
      n.hyst = 1'b1;
    end else if (c.hyst) begin
      n.hyst = 1'b0;
    end else begin
      n.dir  = outcome;
      n.hyst = 1'b0;
    end
    return n;
  endfunction

endpackage

// File: rtl/gskew_fold.sv
module gskew_fold #(
  parameter int IN_W  = 30,
  parameter int OUT_W = 10
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);

  localparam int NCH = (IN_W + OUT_W - 1) / OUT_W;
  localparam int PW  = NCH * OUT_W;

  logic [PW-1:0] pad;

  always_comb begin
    pad  = PW'(din);
    dout = '0;
    for (int k = 0; k < NCH; k++) begin
      dout = dout ^ pad[k*OUT_W +: OUT_W];
    end
  end

endmodule

// File: rtl/gskew_hash.sv
module gskew_hash
  import gskew_pkg::*;
#(
  parameter int PC_W   = 30,
  parameter int HIST_W = 12,
  parameter int IDX_W  = 10
) (
  input  logic [PC_W-1:0]               pc,
  input  logic [HIST_W-1:0]             hist,
  output logic [NLANE-1:0][IDX_W-1:0]   idx
);

  logic [IDX_W-1:0] a;
  logic [IDX_W-1:0] f;
  logic [IDX_W-1:0] a_rev;
  logic [IDX_W-1:0] f_rol;
  logic [IDX_W-1:0] f_ror;

  gskew_fold #(.IN_W(PC_W),   .OUT_W(IDX_W)) u_fold_pc   (.din(pc),   .dout(a));
  gskew_fold #(.IN_W(HIST_W), .OUT_W(IDX_W)) u_fold_hist (.din(hist), .dout(f));

  always_comb begin
    for (int i = 0; i < IDX_W; i++) begin
      a_rev[i] = a[IDX_W-1-i];
    end
    f_rol = {f[IDX_W-2:0], f[IDX_W-1]};
    f_ror = {f[0], f[IDX_W-1:1]};
    idx[L_BIM]  = a;
    idx[L_G0]   = a ^ f_rol;
    idx[L_G1]   = a_rev ^ f_ror;
    idx[L_META] = a ^ f;
  end

endmodule

// File: rtl/gskew_bank.sv
module gskew_bank #(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             re,
  input  logic [IDX_W-1:0] raddr,
  output logic             rdir,
  output logic             rhyst,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic             wdir,
  input  logic             whyst
);

  localparam int DEPTH = 1 << IDX_W;

  logic dir_mem  [DEPTH];
  logic hyst_mem [DEPTH];

  // Direction array: one read port, one write port, read-first.
  always_ff @(posedge clk) begin
    if (we) dir_mem[waddr] <= wdir;
    if (re) rdir <= dir_mem[raddr];
  end

  // Hysteresis array, kept apart so it maps to its own memory.
  always_ff @(posedge clk) begin
    if (we) hyst_mem[waddr] <= whyst;
    if (re) rhyst <= hyst_mem[raddr];
  end

endmodule

// File: rtl/gskew_train.sv
module gskew_train
  import gskew_pkg::*;
(
  input  logic [NLANE-1:0] pbit,
  input  logic [NLANE-1:0] hbit,
  input  logic             taken,
  output logic [NLANE-1:0] we,
  output logic [NLANE-1:0] ndir,
  output logic [NLANE-1:0] nhyst
);

  logic vote, pred, agree, split, correct, new_sel, pred2, rescued;
  ctr_t meta_n;
  ctr_t lane_n;

  always_comb begin
    vote    = maj3(pbit[L_BIM], pbit[L_G0], pbit[L_G1]);
    pred    = pbit[L_META] ? vote : pbit[L_BIM];
    agree   = (pbit[L_BIM] == pbit[L_G0]) && (pbit[L_G0] == pbit[L_G1]);
    split   = (pbit[L_BIM] != vote);
    correct = (pred == taken);
    meta_n  = ctr_step(ctr_t'({pbit[L_META], hbit[L_META]}), vote == taken);
    new_sel = split ? meta_n.dir : pbit[L_META];
    pred2   = new_sel ? vote : pbit[L_BIM];
    rescued = correct || (pred2 == taken);

    we     = '0;
    ndir   = pbit;
    nhyst  = hbit;
    lane_n = '0;

    if (!(correct && agree)) begin
      if (split) begin
        we[L_META]    = 1'b1;
        ndir[L_META]  = meta_n.dir;
        nhyst[L_META] = meta_n.hyst;
      end
      for (int i = 0; i < 3; i++) begin
        if (rescued) begin
          if (pbit[i] == taken) begin
            we[i]    = 1'b1;
            nhyst[i] = 1'b1;
          end
        end else begin
          lane_n   = ctr_step(ctr_t'({pbit[i], hbit[i]}), taken);
          we[i]    = 1'b1;
          ndir[i]  = lane_n.dir;
          nhyst[i] = lane_n.hyst;
        end
      end
    end
  end

endmodule

// File: rtl/gskew_predictor.sv
module gskew_predictor
  import gskew_pkg::*;
#(
  parameter int PC_W   = 30,
  parameter int HIST_W = 12,
  parameter int IDX_W  = 10
) (
  input  logic                          clk,
  input  logic                          rst,
  output logic                          rdy,
  input  logic                          pred_valid,
  input  logic [PC_W-1:0]               pred_pc,
  input  logic [HIST_W-1:0]             pred_hist,
  output logic                          rsp_valid,
  output logic                          rsp_taken,
  output logic [NLANE-1:0][IDX_W-1:0]   rsp_idx,
  output logic [NLANE-1:0]              rsp_pbit,
  output logic [NLANE-1:0]              rsp_hbit,
  input  logic                          upd_valid,
  input  logic                          upd_taken,
  input  logic [NLANE-1:0][IDX_W-1:0]   upd_idx,
  input  logic [NLANE-1:0]              upd_pbit,
  input  logic [NLANE-1:0]              upd_hbit
);

  localparam int DEPTH = 1 << IDX_W;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic                        busy;
  logic [IDX_W-1:0]            clr_addr;
  logic [NLANE-1:0][IDX_W-1:0] ridx;
  logic [NLANE-1:0]            t_we, t_dir, t_hyst;
  logic [NLANE-1:0]            b_we, b_dir, b_hyst;
  logic [NLANE-1:0][IDX_W-1:0] b_addr;

  // Table clear sweep after reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b1;
      clr_addr <= '0;
    end else if (busy) begin
      clr_addr <= clr_addr + 1'b1;
      if (clr_addr == LAST) busy <= 1'b0;
    end
  end

  assign rdy = !busy;

  gskew_hash #(.PC_W(PC_W), .HIST_W(HIST_W), .IDX_W(IDX_W)) u_hash (
    .pc   (pred_pc),
    .hist (pred_hist),
    .idx  (ridx)
  );

  gskew_train u_train (
    .pbit  (upd_pbit),
    .hbit  (upd_hbit),
    .taken (upd_taken),
    .we    (t_we),
    .ndir  (t_dir),
    .nhyst (t_hyst)
  );

  always_comb begin
    for (int b = 0; b < NLANE; b++) begin
      b_we[b]   = busy | (upd_valid & t_we[b]);
      b_addr[b] = busy ? clr_addr : upd_idx[b];
      b_dir[b]  = !busy & t_dir[b];
      b_hyst[b] = !busy & t_hyst[b];
    end
  end

  for (genvar b = 0; b < NLANE; b++) begin : g_lane
    gskew_bank #(.IDX_W(IDX_W)) u_bank (
      .clk   (clk),
      .re    (pred_valid),
      .raddr (ridx[b]),
      .rdir  (rsp_pbit[b]),
      .rhyst (rsp_hbit[b]),
      .we    (b_we[b]),
      .waddr (b_addr[b]),
      .wdir  (b_dir[b]),
      .whyst (b_hyst[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) rsp_valid <= 1'b0;
    else     rsp_valid <= pred_valid & !busy;
  end

  always_ff @(posedge clk) begin
    if (pred_valid) rsp_idx <= ridx;
  end

  assign rsp_taken = rsp_pbit[L_META] ? maj3(rsp_pbit[L_BIM], rsp_pbit[L_G0], rsp_pbit[L_G1])
                                      : rsp_pbit[L_BIM];

endmodule

// File: rtl/gskew_predictor_chk.sv
module gskew_predictor_chk (
  input logic       clk,
  input logic       rst,
  input logic       rdy,
  input logic       pred_valid,
  input logic       rsp_valid,
  input logic       rsp_taken,
  input logic [3:0] rsp_pbit
);

  p_rdy_sticky_r1: assert property (@(posedge clk) disable iff (rst)
    rdy |=> rdy);

  p_busy_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !rdy |=> !rsp_valid);

  p_rsp_latency_r2: assert property (@(posedge clk) disable iff (rst)
    (pred_valid && rdy) |=> rsp_valid);

  p_rsp_source_r2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(pred_valid));

  p_agree_taken_r4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && (rsp_pbit[0] == rsp_pbit[1]) && (rsp_pbit[1] == rsp_pbit[2]))
      |-> (rsp_taken == rsp_pbit[0]));

endmodule

bind gskew_predictor gskew_predictor_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .rdy        (rdy),
  .pred_valid (pred_valid),
  .rsp_valid  (rsp_valid),
  .rsp_taken  (rsp_taken),
  .rsp_pbit   (rsp_pbit)
);

// File: tb/gskew_predictor_tb.sv
module gskew_predictor_tb;

  localparam int PC_W   = 30;
  localparam int HIST_W = 12;
  localparam int IDX_W  = 10;
  localparam int DEPTH  = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rdy;
  logic pred_valid = 1'b0;
  logic [PC_W-1:0] pred_pc = '0;
  logic [HIST_W-1:0] pred_hist = '0;
  logic rsp_valid, rsp_taken;
  logic [3:0][IDX_W-1:0] rsp_idx;
  logic [3:0] rsp_pbit, rsp_hbit;
  logic upd_valid = 1'b0;
  logic upd_taken = 1'b0;
  logic [3:0][IDX_W-1:0] upd_idx = '0;
  logic [3:0] upd_pbit = '0;
  logic [3:0] upd_hbit = '0;

  int nchk = 0;
  int nfail = 0;

  logic m_p [0:3][0:DEPTH-1];
  logic m_h [0:3][0:DEPTH-1];

  always #4 clk = ~clk;

  gskew_predictor #(.PC_W(PC_W), .HIST_W(HIST_W), .IDX_W(IDX_W)) u_dut (
    .clk(clk), .rst(rst), .rdy(rdy),
    .pred_valid(pred_valid), .pred_pc(pred_pc), .pred_hist(pred_hist),
    .rsp_valid(rsp_valid), .rsp_taken(rsp_taken), .rsp_idx(rsp_idx),
    .rsp_pbit(rsp_pbit), .rsp_hbit(rsp_hbit),
    .upd_valid(upd_valid), .upd_taken(upd_taken), .upd_idx(upd_idx),
    .upd_pbit(upd_pbit), .upd_hbit(upd_hbit)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Spec-level index model (R3)
  function automatic logic [IDX_W-1:0] exp_idx(input logic [PC_W-1:0] pc,
                                                input logic [HIST_W-1:0] h, input int lane);
    logic [IDX_W-1:0] a, f, ar;
    a = pc[9:0] ^ pc[19:10] ^ pc[29:20];
    f = h[9:0] ^ {8'b0, h[11:10]};
    for (int i = 0; i < IDX_W; i++) ar[i] = a[IDX_W-1-i];
    case (lane)
      0: return a;
      1: return a ^ {f[8:0], f[9]};
      2: return ar ^ {f[0], f[9:1]};
      default: return a ^ f;
    endcase
  endfunction

  function automatic logic [1:0] step(input logic p, input logic h, input logic o);
    if (p == o) return {p, 1'b1};
    if (h) return {p, 1'b0};
    return {o, 1'b0};
  endfunction

  // Reference training model from R5..R8; returns the requirement tag.
  task automatic model_train(input logic [3:0][IDX_W-1:0] ix, input logic [3:0] p,
                             input logic [3:0] h, input logic o, output string tag);
    logic v, pr, ag, sp, nsel;
    logic [1:0] s;
    v  = (p[0] & p[1]) | (p[0] & p[2]) | (p[1] & p[2]);
    pr = p[3] ? v : p[0];
    ag = (p[0] == p[1]) && (p[1] == p[2]);
    sp = (p[0] != v);
    if (pr == o && ag) begin
      tag = "R6";
      return;
    end
    nsel = p[3];
    if (sp) begin
      s = step(p[3], h[3], v == o);
      m_p[3][ix[3]] = s[1];
      m_h[3][ix[3]] = s[0];
      nsel = s[1];
    end
    if (pr == o || (nsel ? v : p[0]) == o) begin
      tag = (pr == o) ? "R7" : "R8";
      for (int i = 0; i < 3; i++) if (p[i] == o) m_h[i][ix[i]] = 1'b1;
    end else begin
      tag = "R8 R5";
      for (int i = 0; i < 3; i++) begin
        s = step(p[i], h[i], o);
        m_p[i][ix[i]] = s[1];
        m_h[i][ix[i]] = s[0];
      end
    end
  endtask

  task automatic predict(input logic [PC_W-1:0] pc, input logic [HIST_W-1:0] h);
    @(negedge clk);
    pred_valid = 1'b1; pred_pc = pc; pred_hist = h;
    @(negedge clk);
    pred_valid = 1'b0;
  endtask

  task automatic update(input logic [3:0][IDX_W-1:0] ix, input logic [3:0] p,
                        input logic [3:0] h, input logic o);
    @(negedge clk);
    upd_valid = 1'b1; upd_idx = ix; upd_pbit = p; upd_hbit = h; upd_taken = o;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic expect_state(input logic [PC_W-1:0] pc, input logic [HIST_W-1:0] h,
                              output logic [3:0][IDX_W-1:0] ix, output logic [3:0] p,
                              output logic [3:0] hh);
    for (int b = 0; b < 4; b++) begin
      ix[b] = exp_idx(pc, h, b);
      p[b]  = m_p[b][ix[b]];
      hh[b] = m_h[b][ix[b]];
    end
  endtask

  // One resolved branch: predict, check, train, re-read and check.
  task automatic do_branch(input logic [PC_W-1:0] pc, input logic [HIST_W-1:0] h,
                           input logic o);
    logic [3:0][IDX_W-1:0] ix;
    logic [3:0] p, hh;
    logic et;
    string tag;
    expect_state(pc, h, ix, p, hh);
    et = p[3] ? ((p[0] & p[1]) | (p[0] & p[2]) | (p[1] & p[2])) : p[0];
    predict(pc, h);
    chk(rsp_valid == 1'b1, "R2", "rsp_valid", 64'(rsp_valid), 64'd1);
    chk(rsp_idx == ix, "R3", "index lanes", 64'(rsp_idx), 64'(ix));
    chk({rsp_pbit, rsp_hbit} == {p, hh}, "R5", "bits read", 64'({rsp_pbit, rsp_hbit}), 64'({p, hh}));
    chk(rsp_taken == et, "R4", "taken", 64'(rsp_taken), 64'(et));
    model_train(ix, p, hh, o, tag);
    update(ix, p, hh, o);
    expect_state(pc, h, ix, p, hh);
    predict(pc, h);
    chk({rsp_pbit, rsp_hbit} == {p, hh}, tag, "bits after update",
        64'({rsp_pbit, rsp_hbit}), 64'({p, hh}));
  endtask

  task automatic t_reset_clear;  // R1
    int n;
    for (int b = 0; b < 4; b++)
      for (int i = 0; i < DEPTH; i++) begin m_p[b][i] = 1'b0; m_h[b][i] = 1'b0; end
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    n = 0;
    chk(rdy == 1'b0, "R1", "rdy right after reset", 64'(rdy), 64'd0);
    pred_valid = 1'b1; pred_pc = 30'h3; pred_hist = '0;
    @(negedge clk); n++;
    pred_valid = 1'b0;
    chk(rsp_valid == 1'b0, "R1", "response while clearing", 64'(rsp_valid), 64'd0);
    while (!rdy && n < DEPTH + 10) begin @(negedge clk); n++; end
    chk(n == DEPTH, "R1", "clear length", 64'(n), 64'(DEPTH));
    repeat (3) @(negedge clk);
    chk(rdy == 1'b1, "R1", "rdy held", 64'(rdy), 64'd1);
  endtask

  task automatic t_agree_hold;  // R6
    do_branch(30'h0000111, 12'h000, 1'b0);
    do_branch(30'h0000111, 12'h000, 1'b0);
  endtask

  task automatic t_training_path;  // R7, R8
    do_branch(30'h00002A5, 12'h000, 1'b1);
    do_branch(30'h00002A5, 12'h0F3, 1'b1);
    do_branch(30'h00002A5, 12'h0F3, 1'b0);
    do_branch(30'h00002A5, 12'h0F3, 1'b0);
    do_branch(30'h00002A5, 12'h0F3, 1'b0);
  endtask

  task automatic t_index_spread;  // R3
    do_branch(30'h3FFFFFFF, 12'hFFF, 1'b0);
    do_branch(30'h12345678, 12'hC01, 1'b0);
    do_branch(30'h00000001, 12'h400, 1'b0);
  endtask

  task automatic t_collide;  // R9
    logic [3:0][IDX_W-1:0] ix;
    logic [3:0] p, hh;
    string tag;
    expect_state(30'h0000155, 12'h000, ix, p, hh);
    @(negedge clk);
    upd_valid = 1'b1; upd_idx = ix; upd_pbit = p; upd_hbit = hh; upd_taken = 1'b1;
    pred_valid = 1'b1; pred_pc = 30'h0000155; pred_hist = 12'h000;
    @(negedge clk);
    upd_valid = 1'b0; pred_valid = 1'b0;
    chk({rsp_pbit, rsp_hbit} == {p, hh}, "R9", "read during write",
        64'({rsp_pbit, rsp_hbit}), 64'({p, hh}));
    model_train(ix, p, hh, 1'b1, tag);
    expect_state(30'h0000155, 12'h000, ix, p, hh);
    predict(30'h0000155, 12'h000);
    chk({rsp_pbit, rsp_hbit} == {p, hh}, "R9", "read after write",
        64'({rsp_pbit, rsp_hbit}), 64'({p, hh}));
  endtask

  task automatic t_mixed_stream;  // R4..R8 under a mixed pattern
    logic [PC_W-1:0] pc;
    logic [HIST_W-1:0] h;
    for (int k = 0; k < 300; k++) begin
      pc = PC_W'(32'h400 + 32'h37 * ($urandom % 12));
      h  = HIST_W'(($urandom % 5) * 12'h29B);
      do_branch(pc, h, pc[0] ^ (h[1] & pc[2]) ^ (($urandom % 8) == 0));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    t_reset_clear();
    t_agree_hold();
    t_training_path();
    t_index_spread();
    t_collide();
    t_mixed_stream();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule